// File: doc/BRIEF.md
# CMOS Real-Time Clock with Indexed Register Port

This block is a PC-style real-time clock built around 128 bytes of battery-style CMOS storage. The host reaches every byte through a two-location 8-bit port. A write to the even location selects a 7-bit byte index. An access to the odd location reads or writes the byte at that index. A second, write-only configuration port serves two purposes. It preloads any storage byte directly, and it loads the two clock-divider constants: the number of clock cycles in one second and the number of cycles in the periodic base tick of about 122 µs.

Time is kept in BCD inside the storage bytes. Once per programmed second the clock steps forward by one second. The carry runs through minutes, 24-hour hours, weekday, day of month (month length and leap years included), month and two-digit year. Three event flags are collected in the status byte: second update, alarm match and periodic tick. Each flag drives the interrupt line only when its enable bit is set. Reading the status byte returns the flags and clears them.

Top module: `cmos_rtc`

## Requirements
- R1: With io_sel=0 a write stores io_wdata[6:0] as the byte index. With io_sel=1 a write stores io_wdata into the indexed byte, and a read returns that byte on io_rdata one clock later. A read with io_sel=0 returns the index. io_rdata holds its value while io_rd is low.
- R2: A configuration write with cfg_addr below 128 stores cfg_wdata[7:0] into storage byte cfg_addr, one byte per clock. If it collides with a host port write, the configuration write wins.
- R3: A configuration write to address 128 sets the second length to cfg_wdata[26:0] clock cycles. A write to address 129 sets the base tick length to cfg_wdata[12:0] cycles. A length of 0 stops that divider. A length of N gives one event every N cycles.
- R4: Each second event advances the BCD fields one second: seconds (byte 0x00) 59→00, minutes (0x02) 59→00, hours (0x04) 23→00, weekday (0x06) 7→1, and day of month (0x07) past the month length back to 1. Month length is 30 for April, June, September and November, 31 for the other months except February, and 29 for February in a leap year (year divisible by 4, with 00 counting as leap) or 28 otherwise. Month (0x08) then goes 12→1 and year (0x09) 99→00.
- R5: Every second event sets the update flag, bit 4 of the status byte 0x0C.
- R6: The alarm flag, bit 5 of 0x0C, is set at a second event when the new seconds, minutes and hours equal bytes 0x01, 0x03 and 0x05.
- R7: When the rate field (bits 3:0 of byte 0x0A) is r≠0, the periodic flag, bit 6 of 0x0C, is set once every 2^(r-1) base ticks. A rate of 0 never sets it.
- R8: Reading 0x0C returns {irq, periodic, alarm, update, 4'b0000} and clears the three flags. A flag raised in the same clock is kept.
- R9: irq is high exactly when a flag is set whose enable is set in byte 0x0B (bit 6 periodic, bit 5 alarm, bit 4 update). With those enables clear, for example at 0x02, irq stays low.
- R10: Byte 0x0D always reads 0x80 (time and storage valid). Writes to 0x0C or 0x0D from either port are ignored.
- R11: After reset all storage bytes, flags and divider lengths are zero (clock stopped), irq is low and io_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | output | 1 | Interrupt request, level |
| io_sel | input | 1 | Host port location: 0 index, 1 data |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | 8 | Host read data, registered |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address: 0-127 storage, 128 second length, 129 tick length |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
The calendar carry is tried with random start dates biased toward the last second, minute, hour and day of a month, each advanced a random number of seconds and compared with an integer date model. These cases separate a wrong carry stage from a wrong month length. Directed dates cover year rollover, February in leap, non-leap and year-00 cases, and the weekday wrap. Storage traffic mixes random bytes from both ports, which tells a broken index path from a broken preload path. The periodic tick is timed at two rates and with the rate field at zero. Alarm and mask tests compare a near-miss time with the exact match, and enabled interrupts with masked ones.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int OFS_SEC   = 'h00;
   localparam int OFS_ASEC  = 'h01;
   localparam int OFS_MIN   = 'h02;
   localparam int OFS_AMIN  = 'h03;
   localparam int OFS_HOUR  = 'h04;
   localparam int OFS_AHOUR = 'h05;
   localparam int OFS_WDAY  = 'h06;
   localparam int OFS_MDAY  = 'h07;
   localparam int OFS_MON   = 'h08;
   localparam int OFS_YEAR  = 'h09;
   localparam int OFS_RATE  = 'h0A;
   localparam int OFS_EN    = 'h0B;
   localparam int OFS_FLAG  = 'h0C;
   localparam int OFS_VALID = 'h0D;

   localparam logic [7:0] VALID_BYTE = 8'h80;

   // one step of a two-digit BCD counter (no wrap handling)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four, decided on the BCD digits directly
   function automatic logic bcd_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] bcd_month_len(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_cycle_div.sv
module rtc_cycle_div #(
   parameter int CNT_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] limit,
   output logic             strobe
);

   if (CNT_W < 2) begin : g_bad_w
      $error("rtc_cycle_div: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   assign strobe = (limit != '0) && (cnt >= limit - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)                         cnt <= '0;
      else if ((limit == '0) || strobe)   cnt <= '0;
      else                                cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic [RATE_W-1:0] rate,
   output logic              fire
);

   localparam int CNT_W = (1 << RATE_W) - 2;

   if (RATE_W < 2 || RATE_W > 5) begin : g_bad_rate
      $error("rtc_rate_sel: RATE_W must lie in 2..5");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   always_comb begin
      if (rate == '0) mask = '0;
      else            mask = CNT_W'((64'd1 << (rate - RATE_W'(1))) - 64'd1);
   end

   assign fire = base_tick && (rate != '0) && ((cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (base_tick) cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic [7:0] sec,
   input  logic [7:0] min,
   input  logic [7:0] hour,
   input  logic [7:0] wday,
   input  logic [7:0] mday,
   input  logic [7:0] mon,
   input  logic [7:0] year,
   output logic [7:0] n_sec,
   output logic [7:0] n_min,
   output logic [7:0] n_hour,
   output logic [7:0] n_wday,
   output logic [7:0] n_mday,
   output logic [7:0] n_mon,
   output logic [7:0] n_year
);

   logic c_sec, c_min, c_hour, c_mday, c_mon;

   always_comb begin
      c_sec  = (sec  >= 8'h59);
      c_min  = c_sec  && (min  >= 8'h59);
      c_hour = c_min  && (hour >= 8'h23);
      c_mday = c_hour && (mday >= bcd_month_len(mon, year));
      c_mon  = c_mday && (mon  >= 8'h12);

      n_sec  = c_sec ? 8'h00 : bcd_inc(sec);
      n_min  = !c_sec  ? min  : (c_min  ? 8'h00 : bcd_inc(min));
      n_hour = !c_min  ? hour : (c_hour ? 8'h00 : bcd_inc(hour));
      n_wday = !c_hour ? wday : ((wday >= 8'h07) ? 8'h01 : wday + 8'h01);
      n_mday = !c_hour ? mday : (c_mday ? 8'h01 : bcd_inc(mday));
      n_mon  = !c_mday ? mon  : (c_mon  ? 8'h01 : bcd_inc(mon));
      n_year = !c_mon  ? year : ((year >= 8'h99) ? 8'h00 : bcd_inc(year));
   end

endmodule

// File: rtl/cmos_rtc.sv
module cmos_rtc
   import rtc_pkg::*;
#(
   parameter int IDX_W  = 7,
   parameter int SEC_W  = 27,
   parameter int TICK_W = 13,
   parameter int RATE_W = 4,
   parameter int CFG_AW = 8,
   parameter int CFG_DW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              irq,
   input  logic              io_sel,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   input  logic              cfg_wr,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata
);

   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CFG_AW-1:0] CFG_SEC_LEN  = CFG_AW'(DEPTH);
   localparam logic [CFG_AW-1:0] CFG_TICK_LEN = CFG_AW'(DEPTH + 1);
   localparam logic [IDX_W-1:0]  I_FLAG  = IDX_W'(OFS_FLAG);
   localparam logic [IDX_W-1:0]  I_VALID = IDX_W'(OFS_VALID);

   if (IDX_W < 4 || IDX_W > 8) begin : g_bad_idx
      $error("cmos_rtc: IDX_W must lie in 4..8");
   end
   if (CFG_AW <= IDX_W) begin : g_bad_cfg_aw
      $error("cmos_rtc: CFG_AW must exceed IDX_W");
   end
   if (CFG_DW < SEC_W || CFG_DW < TICK_W || CFG_DW < 8) begin : g_bad_cfg_dw
      $error("cmos_rtc: CFG_DW too narrow for the divider lengths");
   end
   if (RATE_W > 4) begin : g_bad_rate_w
      $error("cmos_rtc: rate field must fit the low nibble");
   end

   logic [7:0]        mem [DEPTH];
   logic [IDX_W-1:0]  idx_q;
   logic [SEC_W-1:0]  sec_len;
   logic [TICK_W-1:0] tick_len;
   logic [2:0]        flags;      // {periodic, alarm, update}
   logic              sec_tick, base_tick, per_fire, alarm_hit, c_rd;
   logic [2:0]        irq_en;
   logic [7:0]        sec_now, rd_byte;
   logic [7:0]        n_sec, n_min, n_hour, n_wday, n_mday, n_mon, n_year;
   logic              io_data_wr, cfg_mem_wr;
   logic [IDX_W-1:0]  cfg_idx;

   assign sec_now    = mem[OFS_SEC];
   assign irq_en     = mem[OFS_EN][6:4];
   assign io_data_wr = io_wr && io_sel && (idx_q != I_FLAG) && (idx_q != I_VALID);
   assign cfg_idx    = cfg_addr[IDX_W-1:0];
   assign cfg_mem_wr = cfg_wr && (cfg_addr < CFG_AW'(DEPTH))
                       && (cfg_idx != I_FLAG) && (cfg_idx != I_VALID);
   assign c_rd       = io_rd && io_sel && (idx_q == I_FLAG);

   rtc_cycle_div #(.CNT_W(SEC_W)) u_sec_div (
      .clk(clk), .rst_n(rst_n), .limit(sec_len), .strobe(sec_tick));

   rtc_cycle_div #(.CNT_W(TICK_W)) u_tick_div (
      .clk(clk), .rst_n(rst_n), .limit(tick_len), .strobe(base_tick));

   rtc_rate_sel #(.RATE_W(RATE_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
      .rate(mem[OFS_RATE][RATE_W-1:0]), .fire(per_fire));

   rtc_calendar u_cal (
      .sec(mem[OFS_SEC]), .min(mem[OFS_MIN]), .hour(mem[OFS_HOUR]),
      .wday(mem[OFS_WDAY]), .mday(mem[OFS_MDAY]), .mon(mem[OFS_MON]),
      .year(mem[OFS_YEAR]),
      .n_sec(n_sec), .n_min(n_min), .n_hour(n_hour), .n_wday(n_wday),
      .n_mday(n_mday), .n_mon(n_mon), .n_year(n_year));

   assign alarm_hit = sec_tick && (n_sec == mem[OFS_ASEC])
                      && (n_min == mem[OFS_AMIN]) && (n_hour == mem[OFS_AHOUR]);

   assign irq = |(flags & irq_en);

   always_comb begin
      if (idx_q == I_FLAG)       rd_byte = {irq, flags, 4'b0000};
      else if (idx_q == I_VALID) rd_byte = VALID_BYTE;
      else                       rd_byte = mem[idx_q];
   end

   // storage: calendar step first, host write next, configuration write last
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (sec_tick) begin
            mem[OFS_SEC]  <= n_sec;
            mem[OFS_MIN]  <= n_min;
            mem[OFS_HOUR] <= n_hour;
            mem[OFS_WDAY] <= n_wday;
            mem[OFS_MDAY] <= n_mday;
            mem[OFS_MON]  <= n_mon;
            mem[OFS_YEAR] <= n_year;
         end
         if (io_data_wr) mem[idx_q]   <= io_wdata;
         if (cfg_mem_wr) mem[cfg_idx] <= cfg_wdata[7:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= '0;
         sec_len  <= '0;
         tick_len <= '0;
         flags    <= '0;
         io_rdata <= '0;
      end else begin
         if (io_wr && !io_sel) idx_q <= io_wdata[IDX_W-1:0];
         if (cfg_wr && cfg_addr == CFG_SEC_LEN)  sec_len  <= cfg_wdata[SEC_W-1:0];
         if (cfg_wr && cfg_addr == CFG_TICK_LEN) tick_len <= cfg_wdata[TICK_W-1:0];
         flags <= (flags & ~{3{c_rd}}) | {per_fire, alarm_hit, sec_tick};
         if (io_rd) io_rdata <= io_sel ? rd_byte : 8'(idx_q);
      end
   end

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
   parameter int IDX_W  = 7,
   parameter int CFG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              io_sel,
   input logic              io_rd,
   input logic              io_wr,
   input logic [7:0]        io_rdata,
   input logic              cfg_wr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [IDX_W-1:0]  idx_q,
   input logic [2:0]        flags,
   input logic [2:0]        irq_en,
   input logic              sec_tick,
   input logic              per_fire,
   input logic [7:0]        sec_now
);

   logic sec_byte_wr;
   assign sec_byte_wr = (io_wr && io_sel && idx_q == '0) || (cfg_wr && cfg_addr == '0);

   // R1: read data holds between reads
   p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata));

   // R4: a second event always moves the seconds byte
   p_sec_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !sec_byte_wr) |=> (sec_now != $past(sec_now)));

   // R5: update flag follows every second event
   p_uf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> flags[0]);

   // R8: status read with no new event leaves all flags clear
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_sel && idx_q == IDX_W'(12) && !sec_tick && !per_fire) |=> (flags == 3'b000));

   // R9: no enables, no interrupt
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == 3'b000) |-> !irq);

   // R10: validity byte is constant
   p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_sel && idx_q == IDX_W'(13)) |=> (io_rdata == 8'h80));

endmodule

bind cmos_rtc rtc_chk #(.IDX_W(IDX_W), .CFG_AW(CFG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .io_sel(io_sel), .io_rd(io_rd),
   .io_wr(io_wr), .io_rdata(io_rdata), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
   .idx_q(idx_q), .flags(flags), .irq_en(irq_en), .sec_tick(sec_tick),
   .per_fire(per_fire), .sec_now(sec_now));

// File: tb/cmos_rtc_tb.sv
module cmos_rtc_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq;
   logic        io_sel = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]  io_rdata, io_wdata = '0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   logic irq_seen;
   logic [7:0] shadow [128];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cmos_rtc u_dut (
      .clk(clk), .rst_n(rst_n), .irq(irq), .io_sel(io_sel), .io_rd(io_rd),
      .io_rdata(io_rdata), .io_wr(io_wr), .io_wdata(io_wdata),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic cfg_put(input int a, input int d);
      @(negedge clk); cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = 32'(d);
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic io_put(input int idx, input int v);
      @(negedge clk); io_sel = 1'b0; io_wr = 1'b1; io_wdata = 8'(idx);
      @(negedge clk); io_sel = 1'b1; io_wdata = 8'(v);
      @(negedge clk); io_wr = 1'b0;
   endtask

   task automatic io_get(input int idx, output logic [7:0] v);
      @(negedge clk); io_sel = 1'b0; io_wr = 1'b1; io_wdata = 8'(idx);
      @(negedge clk); io_wr = 1'b0; io_sel = 1'b1; io_rd = 1'b1;
      @(negedge clk); io_rd = 1'b0;
      v = io_rdata;
   endtask

   // second length 1 for exactly k clocks -> k second events
   task automatic advance(input int k);
      irq_seen = 1'b0;
      @(negedge clk); cfg_wr = 1'b1; cfg_addr = 8'd128; cfg_wdata = 32'd1;
      repeat (k) begin
         @(negedge clk);
         cfg_wr = 1'b0;
         if (irq) irq_seen = 1'b1;
      end
      cfg_wr = 1'b1; cfg_wdata = 32'd0;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic wait_rise(output int t);
      t = -1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (irq) begin t = cyc; break; end
      end
   endtask

   // ---- independent integer date model ----
   function automatic int days_in(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic int to_bcd(input int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   typedef struct { int s, m, h, w, d, mo, y; } tm_t;

   function automatic tm_t step(input tm_t t);
      tm_t r = t;
      r.s++;
      if (r.s == 60) begin
         r.s = 0; r.m++;
         if (r.m == 60) begin
            r.m = 0; r.h++;
            if (r.h == 24) begin
               r.h = 0; r.w = (r.w % 7) + 1; r.d++;
               if (r.d > days_in(r.mo, r.y)) begin
                  r.d = 1; r.mo++;
                  if (r.mo == 13) begin r.mo = 1; r.y = (r.y + 1) % 100; end
               end
            end
         end
      end
      return r;
   endfunction

   task automatic load_time(input tm_t t);
      cfg_put('h00, to_bcd(t.s)); cfg_put('h02, to_bcd(t.m)); cfg_put('h04, to_bcd(t.h));
      cfg_put('h06, to_bcd(t.w)); cfg_put('h07, to_bcd(t.d)); cfg_put('h08, to_bcd(t.mo));
      cfg_put('h09, to_bcd(t.y));
   endtask

   task automatic cal_case(input tm_t t0, input int k);
      tm_t e = t0;
      logic [7:0] v;
      load_time(t0);
      advance(k);
      for (int i = 0; i < k; i++) e = step(e);
      io_get('h00, v); chk("R4", "seconds", 32'(v), 32'(to_bcd(e.s)));
      io_get('h02, v); chk("R4", "minutes", 32'(v), 32'(to_bcd(e.m)));
      io_get('h04, v); chk("R4", "hours",   32'(v), 32'(to_bcd(e.h)));
      io_get('h06, v); chk("R4", "weekday", 32'(v), 32'(to_bcd(e.w)));
      io_get('h07, v); chk("R4", "mday",    32'(v), 32'(to_bcd(e.d)));
      io_get('h08, v); chk("R4", "month",   32'(v), 32'(to_bcd(e.mo)));
      io_get('h09, v); chk("R4", "year",    32'(v), 32'(to_bcd(e.y)));
   endtask

   function automatic tm_t mk(input int s, m, h, w, d, mo, y);
      tm_t r;
      r.s = s; r.m = m; r.h = h; r.w = w; r.d = d; r.mo = mo; r.y = y;
      return r;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int t1, t2, t3;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "irq after reset", 32'(irq), 0);
      chk("R11", "rdata after reset", 32'(io_rdata), 0);
      io_get('h0A, v); chk("R11", "byte 0x0A after reset", 32'(v), 0);
      io_get('h00, v); chk("R11", "seconds after reset", 32'(v), 0);
      repeat (20) @(negedge clk);
      io_get('h00, v); chk("R3", "stopped clock holds seconds", 32'(v), 0);

      // R1 / R2: storage through both ports
      for (int i = 0; i < 10; i++) begin
         automatic int a = 'h0E + ($urandom % 114);
         automatic int d = $urandom % 256;
         if (i % 2 == 0) io_put(a, d); else cfg_put(a, d);
         shadow[a] = 8'(d);
         io_get(a, v);
         chk(i % 2 == 0 ? "R1" : "R2", "byte readback", 32'(v), 32'(shadow[a]));
      end
      io_put('h40, 'hA5); cfg_put('h7F, 'h3C);
      io_get('h40, v); chk("R1", "index 0x40", 32'(v), 32'hA5);
      io_get('h7F, v); chk("R2", "preload 0x7F", 32'(v), 32'h3C);
      @(negedge clk); io_sel = 1'b0; io_wr = 1'b1; io_wdata = 8'h33;
      @(negedge clk); io_wr = 1'b0; io_rd = 1'b1;
      @(negedge clk); io_rd = 1'b0;
      chk("R1", "index readback", 32'(io_rdata), 32'h33);
      repeat (3) @(negedge clk);
      chk("R1", "rdata held", 32'(io_rdata), 32'h33);

      // R10: validity byte and read-only status
      io_get('h0D, v); chk("R10", "valid byte", 32'(v), 32'h80);
      io_put('h0D, 'h55); cfg_put('h0D, 'h11);
      io_get('h0D, v); chk("R10", "valid after writes", 32'(v), 32'h80);
      io_put('h0C, 'hF0); cfg_put('h0C, 'hF0);
      io_get('h0C, v); chk("R10", "status after writes", 32'(v), 0);

      // R4: directed corners then random
      cal_case(mk(59, 59, 23, 7, 31, 12, 99), 1);
      cal_case(mk(58, 59, 23, 3, 28, 2, 23), 3);
      cal_case(mk(59, 59, 23, 4, 28, 2, 24), 1);
      cal_case(mk(59, 59, 23, 5, 28, 2, 0), 1);
      cal_case(mk(59, 59, 23, 6, 30, 4, 10), 2);
      cal_case(mk(0, 0, 0, 1, 1, 1, 50), 125);
      for (int i = 0; i < 12; i++) begin
         automatic tm_t t;
         t.mo = 1 + $urandom % 12; t.y = $urandom % 100; t.w = 1 + $urandom % 7;
         t.s = ($urandom % 2) ? 50 + $urandom % 10 : $urandom % 60;
         t.m = ($urandom % 2) ? 59 : $urandom % 60;
         t.h = ($urandom % 2) ? 23 : $urandom % 24;
         t.d = ($urandom % 2) ? days_in(t.mo, t.y) : 1 + $urandom % 28;
         cal_case(t, 1 + $urandom % 130);
      end

      // R9: masked enables
      cfg_put('h01, 'hFF); cfg_put('h03, 'hFF); cfg_put('h05, 'hFF);
      io_put('h0B, 'h02);
      io_get('h0C, v);
      advance(3);
      chk("R9", "irq masked during updates", 32'(irq_seen), 0);
      io_get('h0C, v); chk("R5", "update flag only", 32'(v), 32'h10);
      io_get('h0C, v); chk("R8", "status cleared by read", 32'(v), 0);

      // R6: alarm near-miss then match
      load_time(mk(30, 20, 10, 2, 5, 6, 21));
      cfg_put('h01, 'h35); cfg_put('h03, 'h20); cfg_put('h05, 'h10);
      io_put('h0B, 'h20);
      advance(4);
      chk("R9", "no irq before alarm", 32'(irq), 0);
      io_get('h0C, v); chk("R6", "no alarm at 10:20:34", 32'(v), 32'h10);
      advance(1);
      chk("R9", "irq on alarm", 32'(irq), 1);
      io_get('h0C, v); chk("R6", "alarm at 10:20:35", 32'(v), 32'hB0);
      chk("R8", "irq low after status read", 32'(irq), 0);

      // R7: periodic rates
      io_put('h0B, 'h40);
      cfg_put(129, 8);
      io_put('h0A, 1);
      io_get('h0C, v);
      wait_rise(t1); io_get('h0C, v);
      wait_rise(t2); io_get('h0C, v);
      wait_rise(t3); io_get('h0C, v);
      chk("R7", "rate 1 interval", 32'(t3 - t2), 32'd8);
      chk("R7", "periodic flag in status", 32'(v), 32'hC0);
      cfg_put(129, 5);
      io_put('h0A, 4);
      io_get('h0C, v);
      wait_rise(t1); io_get('h0C, v);
      wait_rise(t2); io_get('h0C, v);
      wait_rise(t3); io_get('h0C, v);
      chk("R7", "rate 4 interval", 32'(t3 - t2), 32'd40);
      io_put('h0A, 0);
      io_get('h0C, v);
      repeat (100) @(negedge clk);
      chk("R7", "rate 0 no irq", 32'(irq), 0);
      io_get('h0C, v); chk("R7", "rate 0 no flag", 32'(v), 0);

      report();
      $finish;
   end

endmodule